// File: doc/BRIEF.md
# Core Power-Up Sequencer

This block is a hardware sequencer that wakes a single processor core in a multi-cluster system. A one-cycle start request names the target cluster and core, and selects one of two platform variants: a single-level reset scheme, or a two-level scheme with an extra power-on reset register. It also selects the core type, small or big. The sequencer then works through its internal control registers one read-modify-write at a time. It puts the core into reset, releases the core's power clamp in nine decreasing steps, and polls an external clamp-sense input until it reads zero. After that it opens the power gates, releases the reset bits, and finally clears the cluster's snoop-inactive bit.

Every wait is a whole number of clock cycles, derived from the clock frequency parameter, with 10 µs per wait. If the clamp sense does not settle within the poll limit, the sequencer aborts and raises a timeout flag. Software or a bench can read back every register through a small select-and-index read port.

Top module: `core_wake_seq`

## Requirements
- R1: A start pulse is accepted only when busy is low, and busy rises in the next cycle. A start that arrives while busy is high has no effect on any register or flag.
- R2: The first action clears the target core's bit in its cluster's core-reset register (read kind 0). In the two-level variant, it also clears the core's bit in the second power-on reset register (kind 2) before the clamp steps start.
- R3: The clamp register (kind 6, bits 7:0) of the target core receives 0xFF shifted right by i, for i = 0..8. Each value is held for 1 + WAIT cycles, where WAIT = (CLK_FREQ_HZ / 1e6) * 10.
- R4: After the last clamp wait, clampSense is sampled once per cycle. A zero sample moves the sequence on. POLL_LIMIT nonzero samples abort it: timeoutErr goes high, busy goes low, and the gating, reset-control, core-release and cluster-control-1 registers are left untouched.
- R5: The power gate register (kind 3) is updated as follows. In the single-level variant, the core's bit and bit 4 are cleared. In the two-level variant, bit 0 is cleared, together with bit 4 for core 0 or the core's own bit for any other core.
- R6: The core's bit in the reset-control register (kind 1) is set. In the two-level variant, the core's bit in kind 2 is also set, followed by one WAIT.
- R7: At core release, kind 0 gains these bits: the core's bit, bit 24, bit 16+core, bit 8 and bit 12. It also gains bit 20+core for a small core, or bit 4+core for a big core.
- R8: For a small core, the core's bit in cluster control 0 (kind 4) is cleared; a big core leaves kind 4 unchanged. The final step clears bit 0 of cluster control 1 (kind 5).
- R9: done and timeoutErr are levels. Both are low while busy, both are cleared by the next accepted start, and they are never high together.
- R10: Reset values are: kinds 0, 1 and 2 = 0, kind 3 = 0x1F, kind 4 = 0xF, kind 5 = 0x1, clamp = 0xFF, and all flags low. Read kind 7 returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start request pulse |
| reqCluster | input | CL_W | Target cluster index |
| reqCore | input | CO_W | Target core index within the cluster |
| reqTwoLevel | input | 1 | 1 selects the two-level reset variant |
| reqBigCore | input | 1 | 1 selects the big core type |
| clampSense | input | 8 | Clamp status seen by the poll step |
| rdKind | input | 3 | Read-back register select |
| rdCluster | input | CL_W | Read-back cluster index |
| rdCore | input | CO_W | Read-back core index (clamp only) |
| rdData | output | 32 | Read-back data |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Last sequence completed |
| timeoutErr | output | 1 | Last sequence aborted by poll timeout |

## Verification
Two events can coincide in a single cycle: a new start request, and the final step or the abort of a running sequence. The bench raises start while busy is high and then confirms two things: the running sequence completes with only its own register updates, and the untouched core's bits match the arithmetic model. Separately, it holds clampSense nonzero across the whole poll window, to force the abort and the clamp-sense decision into the same step. It then judges the outcome from the flags and the untouched gating register.

// File: rtl/core_wake_pkg.sv
package core_wake_pkg;

  localparam int DATA_W = 32;

  // Core-release bit positions
  localparam int SOC_DBG_BIT = 24;
  localparam int ETM_BASE    = 20;
  localparam int DBG_BASE    = 16;
  localparam int HRST_BIT    = 12;
  localparam int L2_BIT      = 8;
  localparam int CX_BASE     = 4;

  // Gate bit positions
  localparam int GATE_CL_SINGLE = 4;
  localparam int GATE_CL_TWO    = 0;

  localparam int CLAMP_STEPS = 9;

  localparam logic [DATA_W-1:0] RST_CORE  = '0;
  localparam logic [DATA_W-1:0] RST_POR   = '0;
  localparam logic [DATA_W-1:0] RST_POR2  = '0;
  localparam logic [DATA_W-1:0] RST_GATE  = 32'h0000_001F;
  localparam logic [DATA_W-1:0] RST_CTRL0 = 32'h0000_000F;
  localparam logic [DATA_W-1:0] RST_CTRL1 = 32'h0000_0001;
  localparam logic [7:0]        RST_CLAMP = 8'hFF;

  typedef enum logic [2:0] {
    KIND_CORE  = 3'd0,
    KIND_POR   = 3'd1,
    KIND_POR2  = 3'd2,
    KIND_GATE  = 3'd3,
    KIND_CTRL0 = 3'd4,
    KIND_CTRL1 = 3'd5,
    KIND_CLAMP = 3'd6
  } regKind_e;

  typedef struct packed {
    logic       coreRstClr;
    logic       por2Clr;
    logic       l1Clr;
    logic       clampWr;
    logic [3:0] clampStep;
    logic       gateClr;
    logic       porSet;
    logic       por2Set;
    logic       coreRelease;
    logic       aceClr;
  } seqStrobes_t;

endpackage

// File: rtl/core_wake_ctrl.sv
module core_wake_ctrl
  import core_wake_pkg::*;
#(
  parameter int NUM_CLUSTERS      = 2,
  parameter int CORES_PER_CLUSTER = 4,
  parameter int CLK_FREQ_HZ       = 250_000_000,
  parameter int WAIT_US           = 10,
  parameter int POLL_LIMIT        = 100_000,
  localparam int CL_W     = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1,
  localparam int CO_W     = (CORES_PER_CLUSTER > 1) ? $clog2(CORES_PER_CLUSTER) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            start,
  input  logic [CL_W-1:0] reqCluster,
  input  logic [CO_W-1:0] reqCore,
  input  logic            reqTwoLevel,
  input  logic            reqBigCore,
  input  logic [7:0]      clampSense,
  output seqStrobes_t     strobes,
  output logic [CL_W-1:0] tgtCluster,
  output logic [CO_W-1:0] tgtCore,
  output logic            tgtTwoLevel,
  output logic            tgtBig,
  output logic            busy,
  output logic            done,
  output logic            timeoutErr
);

  localparam int RAW_WAIT = (CLK_FREQ_HZ / 1_000_000) * WAIT_US;
  localparam int WAIT_CYC = (RAW_WAIT > 0) ? RAW_WAIT : 1;
  localparam int WAIT_W   = $clog2(WAIT_CYC + 1);
  localparam int POLL_W   = $clog2(POLL_LIMIT + 1);
  localparam logic [WAIT_W-1:0] WAIT_LAST = WAIT_W'(WAIT_CYC - 1);
  localparam logic [POLL_W-1:0] POLL_LAST = POLL_W'(POLL_LIMIT - 1);
  localparam logic [3:0]        STEP_LAST = 4'(CLAMP_STEPS - 1);

  typedef enum logic [3:0] {
    S_IDLE, S_CORE_HOLD, S_POR2_HOLD, S_L1_OFF, S_CLAMP_WR, S_CLAMP_WAIT,
    S_POLL, S_GATE, S_POR_REL, S_POR2_REL, S_POR2_WAIT, S_CORE_REL, S_ACE_CLR
  } seqState_e;

  seqState_e state;
  logic [WAIT_W-1:0] waitCnt;
  logic [POLL_W-1:0] pollCnt;
  logic [3:0]        step;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= S_IDLE;
      waitCnt     <= '0;
      pollCnt     <= '0;
      step        <= '0;
      tgtCluster  <= '0;
      tgtCore     <= '0;
      tgtTwoLevel <= 1'b0;
      tgtBig      <= 1'b0;
      done        <= 1'b0;
      timeoutErr  <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (start) begin
          tgtCluster  <= reqCluster;
          tgtCore     <= reqCore;
          tgtTwoLevel <= reqTwoLevel;
          tgtBig      <= reqBigCore;
          done        <= 1'b0;
          timeoutErr  <= 1'b0;
          state       <= S_CORE_HOLD;
        end
        S_CORE_HOLD: begin
          step <= '0;
          if (tgtTwoLevel)  state <= S_POR2_HOLD;
          else if (!tgtBig) state <= S_L1_OFF;
          else              state <= S_CLAMP_WR;
        end
        S_POR2_HOLD: state <= tgtBig ? S_CLAMP_WR : S_L1_OFF;
        S_L1_OFF:    state <= S_CLAMP_WR;
        S_CLAMP_WR: begin
          waitCnt <= '0;
          state   <= S_CLAMP_WAIT;
        end
        S_CLAMP_WAIT: begin
          if (waitCnt == WAIT_LAST) begin
            if (step == STEP_LAST) begin
              pollCnt <= '0;
              state   <= S_POLL;
            end else begin
              step  <= step + 4'd1;
              state <= S_CLAMP_WR;
            end
          end else begin
            waitCnt <= waitCnt + 1'b1;
          end
        end
        S_POLL: begin
          if (clampSense == 8'h00) begin
            state <= S_GATE;
          end else if (pollCnt == POLL_LAST) begin
            timeoutErr <= 1'b1;
            state      <= S_IDLE;
          end else begin
            pollCnt <= pollCnt + 1'b1;
          end
        end
        S_GATE:    state <= S_POR_REL;
        S_POR_REL: state <= tgtTwoLevel ? S_POR2_REL : S_CORE_REL;
        S_POR2_REL: begin
          waitCnt <= '0;
          state   <= S_POR2_WAIT;
        end
        S_POR2_WAIT: begin
          if (waitCnt == WAIT_LAST) state <= S_CORE_REL;
          else                      waitCnt <= waitCnt + 1'b1;
        end
        S_CORE_REL: state <= S_ACE_CLR;
        S_ACE_CLR: begin
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes             = '0;
    strobes.clampStep   = step;
    strobes.coreRstClr  = (state == S_CORE_HOLD);
    strobes.por2Clr     = (state == S_POR2_HOLD);
    strobes.l1Clr       = (state == S_L1_OFF);
    strobes.clampWr     = (state == S_CLAMP_WR);
    strobes.gateClr     = (state == S_GATE);
    strobes.porSet      = (state == S_POR_REL);
    strobes.por2Set     = (state == S_POR2_REL);
    strobes.coreRelease = (state == S_CORE_REL);
    strobes.aceClr      = (state == S_ACE_CLR);
  end

endmodule

// File: rtl/core_wake_regs.sv
module core_wake_regs
  import core_wake_pkg::*;
#(
  parameter int NUM_CLUSTERS      = 2,
  parameter int CORES_PER_CLUSTER = 4,
  localparam int CL_W = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1,
  localparam int CO_W = (CORES_PER_CLUSTER > 1) ? $clog2(CORES_PER_CLUSTER) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobes_t       strobes,
  input  logic [CL_W-1:0]   tgtCluster,
  input  logic [CO_W-1:0]   tgtCore,
  input  logic              tgtTwoLevel,
  input  logic              tgtBig,
  input  logic [2:0]        rdKind,
  input  logic [CL_W-1:0]   rdCluster,
  input  logic [CO_W-1:0]   rdCore,
  output logic [DATA_W-1:0] rdData
);

  logic [NUM_CLUSTERS-1:0][DATA_W-1:0] coreRstV, porV, por2V, gateV, ctrl0V, ctrl1V;
  logic [NUM_CLUSTERS-1:0][CORES_PER_CLUSTER-1:0][7:0] clampV;

  logic [DATA_W-1:0] coreBit, releaseMask, gateMask;
  logic [7:0]        clampVal;

  always_comb begin
    coreBit     = DATA_W'(1) << tgtCore;
    releaseMask = coreBit
                | (DATA_W'(1) << SOC_DBG_BIT)
                | (DATA_W'(1) << (DBG_BASE + int'(tgtCore)))
                | (DATA_W'(1) << L2_BIT)
                | (DATA_W'(1) << HRST_BIT)
                | (tgtBig ? (DATA_W'(1) << (CX_BASE + int'(tgtCore)))
                          : (DATA_W'(1) << (ETM_BASE + int'(tgtCore))));
    if (tgtTwoLevel)
      gateMask = (DATA_W'(1) << GATE_CL_TWO)
               | ((tgtCore == '0) ? (DATA_W'(1) << GATE_CL_SINGLE) : coreBit);
    else
      gateMask = coreBit | (DATA_W'(1) << GATE_CL_SINGLE);
    clampVal = 8'hFF >> strobes.clampStep;
  end

  for (genvar g = 0; g < NUM_CLUSTERS; g++) begin : gCluster
    logic hitC;
    logic [DATA_W-1:0] coreRstR, porR, por2R, gateR, ctrl0R, ctrl1R;
    assign hitC = (int'(tgtCluster) == g);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        coreRstR <= RST_CORE;
        porR     <= RST_POR;
        por2R    <= RST_POR2;
        gateR    <= RST_GATE;
        ctrl0R   <= RST_CTRL0;
        ctrl1R   <= RST_CTRL1;
      end else if (hitC) begin
        if (strobes.coreRstClr)  coreRstR <= coreRstR & ~coreBit;
        if (strobes.coreRelease) coreRstR <= coreRstR | releaseMask;
        if (strobes.por2Clr)     por2R    <= por2R & ~coreBit;
        if (strobes.por2Set)     por2R    <= por2R | coreBit;
        if (strobes.porSet)      porR     <= porR | coreBit;
        if (strobes.l1Clr)       ctrl0R   <= ctrl0R & ~coreBit;
        if (strobes.gateClr)     gateR    <= gateR & ~gateMask;
        if (strobes.aceClr)      ctrl1R   <= ctrl1R & ~DATA_W'(1);
      end
    end

    assign coreRstV[g] = coreRstR;
    assign porV[g]     = porR;
    assign por2V[g]    = por2R;
    assign gateV[g]    = gateR;
    assign ctrl0V[g]   = ctrl0R;
    assign ctrl1V[g]   = ctrl1R;

    for (genvar h = 0; h < CORES_PER_CLUSTER; h++) begin : gCore
      logic [7:0] clampR;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)
          clampR <= RST_CLAMP;
        else if (hitC && strobes.clampWr && (int'(tgtCore) == h))
          clampR <= clampVal;
      end
      assign clampV[g][h] = clampR;
    end
  end

  always_comb begin
    unique case (rdKind)
      KIND_CORE:  rdData = coreRstV[rdCluster];
      KIND_POR:   rdData = porV[rdCluster];
      KIND_POR2:  rdData = por2V[rdCluster];
      KIND_GATE:  rdData = gateV[rdCluster];
      KIND_CTRL0: rdData = ctrl0V[rdCluster];
      KIND_CTRL1: rdData = ctrl1V[rdCluster];
      KIND_CLAMP: rdData = DATA_W'(clampV[rdCluster][rdCore]);
      default:    rdData = '0;
    endcase
  end

endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
  import core_wake_pkg::*;
#(
  parameter int NUM_CLUSTERS      = 2,
  parameter int CORES_PER_CLUSTER = 4,
  parameter int CLK_FREQ_HZ       = 250_000_000,
  parameter int WAIT_US           = 10,
  parameter int POLL_LIMIT        = 100_000,
  localparam int CL_W = (NUM_CLUSTERS > 1) ? $clog2(NUM_CLUSTERS) : 1,
  localparam int CO_W = (CORES_PER_CLUSTER > 1) ? $clog2(CORES_PER_CLUSTER) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [CL_W-1:0]   reqCluster,
  input  logic [CO_W-1:0]   reqCore,
  input  logic              reqTwoLevel,
  input  logic              reqBigCore,
  input  logic [7:0]        clampSense,
  input  logic [2:0]        rdKind,
  input  logic [CL_W-1:0]   rdCluster,
  input  logic [CO_W-1:0]   rdCore,
  output logic [DATA_W-1:0] rdData,
  output logic              busy,
  output logic              done,
  output logic              timeoutErr
);

  seqStrobes_t     strobes;
  logic [CL_W-1:0] tgtCluster;
  logic [CO_W-1:0] tgtCore;
  logic            tgtTwoLevel;
  logic            tgtBig;

  core_wake_ctrl #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .CORES_PER_CLUSTER(CORES_PER_CLUSTER),
    .CLK_FREQ_HZ(CLK_FREQ_HZ), .WAIT_US(WAIT_US), .POLL_LIMIT(POLL_LIMIT)
  ) ctrlInst (
    .clk(clk), .rstN(rstN), .start(start),
    .reqCluster(reqCluster), .reqCore(reqCore),
    .reqTwoLevel(reqTwoLevel), .reqBigCore(reqBigCore),
    .clampSense(clampSense), .strobes(strobes),
    .tgtCluster(tgtCluster), .tgtCore(tgtCore),
    .tgtTwoLevel(tgtTwoLevel), .tgtBig(tgtBig),
    .busy(busy), .done(done), .timeoutErr(timeoutErr)
  );

  core_wake_regs #(
    .NUM_CLUSTERS(NUM_CLUSTERS), .CORES_PER_CLUSTER(CORES_PER_CLUSTER)
  ) regsInst (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .tgtCluster(tgtCluster), .tgtCore(tgtCore),
    .tgtTwoLevel(tgtTwoLevel), .tgtBig(tgtBig),
    .rdKind(rdKind), .rdCluster(rdCluster), .rdCore(rdCore),
    .rdData(rdData)
  );

endmodule

// File: rtl/core_wake_checker.sv
module core_wake_checker
  import core_wake_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic        timeoutErr,
  input logic [7:0]  clampSense,
  input seqStrobes_t strobes
);

  logic [3:0] clampCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                clampCnt <= '0;
    else if (!busy)           clampCnt <= '0;
    else if (strobes.clampWr) clampCnt <= clampCnt + 4'd1;
  end

  assert_busy_needs_start_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  assert_nine_steps_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gateClr |-> (clampCnt == 4'(CLAMP_STEPS)));

  assert_gate_after_zero_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.gateClr |-> ($past(clampSense) == 8'h00));

  assert_flags_exclusive_R9: assert property (@(posedge clk) disable iff (!rstN)
    !(done && timeoutErr));

  assert_quiet_while_busy_R9: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (!done && !timeoutErr));

  assert_end_reports_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done ^ timeoutErr));

endmodule

bind core_wake_seq core_wake_checker chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .timeoutErr(timeoutErr), .clampSense(clampSense), .strobes(strobes)
);

// File: tb/core_wake_seq_test.sv
module core_wake_seq_test;

  localparam int NCL   = 2;
  localparam int NCO   = 4;
  localparam int FREQ  = 1_000_000;
  localparam int WAITC = (FREQ / 1_000_000) * 10;
  localparam int PLIM  = 20;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [0:0]  reqCluster = '0;
  logic [1:0]  reqCore = '0;
  logic        reqTwoLevel = 1'b0;
  logic        reqBigCore = 1'b0;
  logic [7:0]  clampSense = 8'h00;
  logic [2:0]  rdKind = '0;
  logic [0:0]  rdCluster = '0;
  logic [1:0]  rdCore = '0;
  logic [31:0] rdData;
  logic        busy, done, timeoutErr;

  int testCount = 0;
  int failCount = 0;

  logic [31:0] mReg [NCL][6];
  logic [7:0]  mClamp [NCL][NCO];

  always #2 clk = ~clk;

  core_wake_seq #(
    .NUM_CLUSTERS(NCL), .CORES_PER_CLUSTER(NCO),
    .CLK_FREQ_HZ(FREQ), .WAIT_US(10), .POLL_LIMIT(PLIM)
  ) uut (
    .clk(clk), .rstN(rstN), .start(start),
    .reqCluster(reqCluster), .reqCore(reqCore),
    .reqTwoLevel(reqTwoLevel), .reqBigCore(reqBigCore),
    .clampSense(clampSense), .rdKind(rdKind), .rdCluster(rdCluster),
    .rdCore(rdCore), .rdData(rdData), .busy(busy), .done(done),
    .timeoutErr(timeoutErr)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp,
                       input string req, input string ctx);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s %s actual=%h expected=%h", req, ctx, act, exp);
    end
  endtask

  task automatic readReg(input int kind, input int cl, input int co,
                         output logic [31:0] v);
    rdKind = 3'(kind); rdCluster = 1'(cl); rdCore = 2'(co);
    #1 v = rdData;
  endtask

  function automatic string kindReq(input int k);
    case (k)
      0: return "R7";
      1: return "R6";
      2: return "R2/R6";
      3: return "R5";
      4: return "R8";
      default: return "R8";
    endcase
  endfunction

  task automatic checkAll(input string ctx);
    logic [31:0] v;
    for (int cl = 0; cl < NCL; cl++) begin
      for (int k = 0; k < 6; k++) begin
        readReg(k, cl, 0, v);
        check(v, mReg[cl][k], kindReq(k), $sformatf("%s cl%0d kind%0d", ctx, cl, k));
      end
      for (int co = 0; co < NCO; co++) begin
        readReg(6, cl, co, v);
        check(v, 32'(mClamp[cl][co]), "R3", $sformatf("%s clamp cl%0d co%0d", ctx, cl, co));
      end
    end
  endtask

  task automatic modelFront(input int cl, input int co, input int two, input int big);
    mReg[cl][0] &= ~(32'd1 << co);
    if (two != 0) mReg[cl][2] &= ~(32'd1 << co);
    if (big == 0) mReg[cl][4] &= ~(32'd1 << co);
    mClamp[cl][co] = 8'h00;
  endtask

  task automatic modelFull(input int cl, input int co, input int two, input int big);
    modelFront(cl, co, two, big);
    if (two == 0) mReg[cl][3] &= ~((32'd1 << co) | (32'd1 << 4));
    else          mReg[cl][3] &= ~(32'd1 | ((co == 0) ? (32'd1 << 4) : (32'd1 << co)));
    mReg[cl][1] |= (32'd1 << co);
    if (two != 0) mReg[cl][2] |= (32'd1 << co);
    mReg[cl][0] |= (32'd1 << co) | (32'd1 << 24) | (32'd1 << (16 + co)) |
                   (32'd1 << 8) | (32'd1 << 12) |
                   ((big != 0) ? (32'd1 << (4 + co)) : (32'd1 << (20 + co)));
    mReg[cl][5] &= ~32'd1;
  endtask

  task automatic pulseStart(input int cl, input int co, input int two, input int big);
    @(negedge clk);
    reqCluster = 1'(cl); reqCore = 2'(co);
    reqTwoLevel = 1'(two); reqBigCore = 1'(big);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 2000) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCount++;
    $display("FAIL watchdog (all R) actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    logic [31:0] v;
    for (int cl = 0; cl < NCL; cl++) begin
      mReg[cl][0] = 32'h0; mReg[cl][1] = 32'h0; mReg[cl][2] = 32'h0;
      mReg[cl][3] = 32'h1F; mReg[cl][4] = 32'hF; mReg[cl][5] = 32'h1;
      for (int co = 0; co < NCO; co++) mClamp[cl][co] = 8'hFF;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R10: reset state
    check(32'(busy), 0, "R10", "busy after reset");
    check(32'(done), 0, "R10", "done after reset");
    check(32'(timeoutErr), 0, "R10", "timeoutErr after reset");
    readReg(7, 0, 0, v);
    check(v, 0, "R10", "kind7 reads zero");
    checkAll("R10 reset");

    // R3: staircase values and hold times, cluster 0 core 1, single-level small
    begin
      logic [7:0] prev;
      int hold = 0;
      int trans = 0;
      pulseStart(0, 1, 0, 0);
      check(32'(busy), 1, "R1", "busy after accepted start");
      rdKind = 3'd6; rdCluster = 1'b0; rdCore = 2'd1;
      #1 prev = rdData[7:0];
      while (busy) begin
        @(negedge clk);
        #1;
        hold++;
        if (rdData[7:0] != prev) begin
          check(32'(rdData[7:0]), 32'(8'hFF >> (trans + 1)), "R3",
                $sformatf("staircase value %0d", trans));
          if (trans > 0)
            check(hold, WAITC + 1, "R3", $sformatf("hold of step %0d", trans));
          trans++;
          hold = 0;
          prev = rdData[7:0];
        end
      end
      check(trans, 8, "R3", "number of clamp changes");
    end
    check(32'(done), 1, "R9", "done after first run");
    check(32'(timeoutErr), 0, "R9", "no timeout first run");
    modelFull(0, 1, 0, 0);
    checkAll("R3 first run");

    // R1: start while busy is ignored
    pulseStart(1, 2, 1, 1);
    check(32'(done), 0, "R9", "done cleared on new start");
    repeat (4) @(negedge clk);
    pulseStart(0, 3, 0, 0);
    waitIdle();
    check(32'(done), 1, "R1", "first sequence completed");
    modelFull(1, 2, 1, 1);
    checkAll("R1 ignored start");

    // Sweep every target and variant
    for (int cl = 0; cl < NCL; cl++)
      for (int co = 0; co < NCO; co++)
        for (int two = 0; two < 2; two++)
          for (int big = 0; big < 2; big++) begin
            pulseStart(cl, co, two, big);
            waitIdle();
            check(32'(done), 1, "R9", $sformatf("done cl%0d co%0d t%0d b%0d", cl, co, two, big));
            modelFull(cl, co, two, big);
            checkAll($sformatf("R5 R7 sweep cl%0d co%0d t%0d b%0d", cl, co, two, big));
          end

    // R2: rerun a released core and observe reset bits cleared mid-sequence
    pulseStart(0, 2, 1, 0);
    repeat (5) @(negedge clk);
    readReg(0, 0, 0, v);
    check(32'(v[2]), 0, "R2", "core reset bit held mid-sequence");
    readReg(2, 0, 0, v);
    check(32'(v[2]), 0, "R2", "second reset bit held mid-sequence");
    waitIdle();
    modelFull(0, 2, 1, 0);
    checkAll("R2 rerun");

    // R4: timeout with clamp sense stuck nonzero
    clampSense = 8'h01;
    pulseStart(1, 3, 0, 1);
    waitIdle();
    check(32'(timeoutErr), 1, "R4", "timeout flagged");
    check(32'(done), 0, "R4", "no done on timeout");
    modelFront(1, 3, 0, 1);
    checkAll("R4 timeout");

    // R4/R9: sense settles late, sequence completes and clears the timeout
    clampSense = 8'h80;
    pulseStart(1, 0, 1, 1);
    check(32'(timeoutErr), 0, "R9", "timeout cleared on start");
    repeat (105) @(negedge clk);
    clampSense = 8'h00;
    waitIdle();
    check(32'(done), 1, "R4", "late settle completes");
    check(32'(timeoutErr), 0, "R4", "late settle no timeout");
    modelFull(1, 0, 1, 1);
    checkAll("R4 late settle");

    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule